// File: doc/BRIEF.md
# Paired-Unit Comparison Self-Test Tile

This tile tests two copies of the same configured unit by driving both with one pattern stream and comparing what comes back. No expected responses are stored anywhere. If the two copies ever disagree on the compared output bits, a fault is present in one of them. The tile does not contain the units. It drives their inputs and receives their two response buses.

Two stimulus modes are available:
- **Exhaustive counter mode** is for combinational units. It presents every input vector in turn.
- **March sequence mode** is for small memories. It walks the address space with a fixed list of write and read elements. Only read cycles are compared.

A start pulse clears the generator and the analyser and begins a run. A done flag marks the end of the run. A sticky fail bit holds the verdict.

The fail bit is also one stage of a serial scan chain. While scan-enable is high, the bit loads from the previous stage and the comparator is ignored. The pattern generator is frozen during that time, so no compare is lost.

A self-check option inverts the second unit's response before comparison. This forces a mismatch and proves the fail bit is able to leave the pass state. The number of compared output bits is chosen for each run.

Top module: `bist_pair_tile`

## Requirements
- R1: After reset the outputs are as follows: busy_o, done_o, scan_out_o, mem_we_o, stim_o and mem_addr_o are all 0.
- R2: A start_i sampled high at a clock edge clears the fail bit (scan_out_o reads 0) and sets busy_o from the next cycle. A start during a run restarts the run. The mode_i, selfchk_i and act_outs_i values are captured at the same edge.
- R3: In counter mode (mode_i=0), stim_o takes the values 0, 1, ..., 2^IN_W-1 on consecutive non-held cycles, starting with the cycle after start. During counter mode, mem_we_o and mem_addr_o stay 0.
- R4: In march mode (mode_i=1), the generator visits every address with six elements, one cycle per operation:
  - element 0, ascending: write 0;
  - element 1, ascending: read, then write all-ones;
  - element 2, ascending: read, then write 0;
  - element 3, descending: read, then write all-ones;
  - element 4, descending: read, then write 0;
  - element 5, ascending: read.

  A write shows mem_we_o=1 and mem_wdata_o all zeros or all ones. A read shows mem_we_o=0. stim_o stays 0 throughout.
- R5: In a compared cycle, any difference between resp_a_i and resp_b_i sets the fail bit. A compared cycle is every run cycle in counter mode, and every read cycle in march mode. Only output bits with index below the captured width count. The new fail value appears on scan_out_o at the next edge. Outside a run the comparator never sets the bit.
- R6: Once set, the fail bit stays 1 until the next start or a scan shift.
- R7: done_o rises at the edge that follows the last pattern cycle, and the final compare result is included in the fail bit at that edge. busy_o falls at the same edge. busy_o and done_o are never high together. done_o then holds until the next start.
- R8: With scan_en_i high (and no start), each edge loads scan_in_i into the fail bit. During that time the comparator is ignored, and stim_o, mem_addr_o and mem_we_o hold their values.
- R9: A run started with selfchk_i=1 compares resp_a_i against the bitwise inverse of resp_b_i. With identical units, such a run ends failed whenever at least one output bit is compared.
- R10: The compare width act_outs_i is captured at start. A width of 0 compares nothing, and widths above OUT_W compare all bits. Differences in bits at or above the width never set the fail bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears generator and analyser, begins a run |
| mode_i | input | 1 | 0 = exhaustive counter, 1 = march memory sequence |
| selfchk_i | input | 1 | Invert unit B responses to force a mismatch |
| act_outs_i | input | ACT_W | Number of low response bits to compare |
| scan_en_i | input | 1 | Shift the fail bit and freeze the generator |
| scan_in_i | input | 1 | Serial data from the previous chain stage |
| resp_a_i | input | OUT_W | Response of unit A |
| resp_b_i | input | OUT_W | Response of unit B |
| stim_o | output | IN_W | Counter-mode input vector to both units |
| mem_addr_o | output | ADDR_W | March-mode address to both memories |
| mem_wdata_o | output | OUT_W | March-mode write data |
| mem_we_o | output | 1 | March-mode write strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, verdict final |
| scan_out_o | output | 1 | Fail bit, also serial output to the next stage |

## Verification
The hardest condition to reach is a fault that shows up only on the very last pattern. Here the fail bit and done_o must change at the same edge. A second hard case is a compare that falls inside a scan-enable hold and must be deferred rather than lost.

The bench models both units itself. It injects a single-vector difference into unit B's function at every possible counter value in turn. It also injects a stuck read bit at every memory address in turn. This makes the last-pattern case and every detection cycle occur naturally. A scan-enable hold is then placed over one pattern mid-run to confirm the generator freezes and resumes on the same vector.

// File: rtl/bist_pkg.sv
`timescale 1ns/1ps
package bist_pkg;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_DONE = 2'd2} run_st_e;

    localparam logic [2:0] LAST_ELEM = 3'd5;

    // elements 1..4 have a read followed by a write
    function automatic logic elem_pair(input logic [2:0] e);
        return (e >= 3'd1) && (e <= 3'd4);
    endfunction

    // elements 3 and 4 walk the addresses downward
    function automatic logic elem_down(input logic [2:0] e);
        return (e == 3'd3) || (e == 3'd4);
    endfunction

    // write value of the element: ones for 1 and 3, zeros otherwise
    function automatic logic elem_wval(input logic [2:0] e);
        return (e == 3'd1) || (e == 3'd3);
    endfunction
endpackage

// File: rtl/bist_seq.sv
`timescale 1ns/1ps
module bist_seq
    import bist_pkg::*;
#(
    parameter int unsigned IN_W   = 4,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned OUT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              hold_i,
    output logic [IN_W-1:0]   stim_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [OUT_W-1:0]  wdata_o,
    output logic              we_o,
    output logic              cmp_en_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [IN_W-1:0]   CNT_MAX  = '1;
    localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

    typedef struct packed {
        run_st_e           st;
        logic              mode;
        logic [IN_W-1:0]   cnt;
        logic [2:0]        elem;
        logic [ADDR_W-1:0] addr;
        logic              op;
    } seq_t;

    seq_t seq_d, seq_q;
    logic addr_end, is_wr, is_rd, run;

    always_comb begin
        run      = (seq_q.st == ST_RUN);
        addr_end = elem_down(seq_q.elem) ? (seq_q.addr == '0) : (seq_q.addr == ADDR_MAX);
        is_wr    = run && seq_q.mode &&
                   ((seq_q.elem == 3'd0) || (elem_pair(seq_q.elem) && seq_q.op));
        is_rd    = run && seq_q.mode && !is_wr;

        seq_d = seq_q;
        if (start_i) begin
            seq_d.st   = ST_RUN;
            seq_d.mode = mode_i;
            seq_d.cnt  = '0;
            seq_d.elem = 3'd0;
            seq_d.addr = '0;
            seq_d.op   = 1'b0;
        end else if (run && !hold_i) begin
            if (!seq_q.mode) begin
                if (seq_q.cnt == CNT_MAX) seq_d.st  = ST_DONE;
                else                      seq_d.cnt = seq_q.cnt + 1'b1;
            end else if (elem_pair(seq_q.elem) && !seq_q.op) begin
                seq_d.op = 1'b1;
            end else begin
                seq_d.op = 1'b0;
                if (addr_end) begin
                    if (seq_q.elem == LAST_ELEM) begin
                        seq_d.st = ST_DONE;
                    end else begin
                        seq_d.elem = seq_q.elem + 3'd1;
                        seq_d.addr = elem_down(seq_q.elem + 3'd1) ? ADDR_MAX : '0;
                    end
                end else begin
                    seq_d.addr = elem_down(seq_q.elem) ? seq_q.addr - 1'b1 : seq_q.addr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign stim_o   = (run && !seq_q.mode) ? seq_q.cnt : '0;
    assign addr_o   = (run && seq_q.mode) ? seq_q.addr : '0;
    assign we_o     = is_wr;
    assign wdata_o  = {OUT_W{is_wr && elem_wval(seq_q.elem)}};
    assign cmp_en_o = run && !hold_i && (!seq_q.mode || is_rd);
    assign busy_o   = run;
    assign done_o   = (seq_q.st == ST_DONE);
endmodule

// File: rtl/bist_ora.sv
`timescale 1ns/1ps
module bist_ora #(
    parameter int unsigned OUT_W = 2,
    parameter int unsigned ACT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             selfchk_i,
    input  logic [ACT_W-1:0] act_i,
    input  logic             scan_en_i,
    input  logic             scan_in_i,
    input  logic             cmp_en_i,
    input  logic [OUT_W-1:0] resp_a_i,
    input  logic [OUT_W-1:0] resp_b_i,
    output logic             fail_o
);
    typedef struct packed {
        logic             fail;
        logic             inv;
        logic [ACT_W-1:0] act;
    } ora_t;

    ora_t ora_d, ora_q;
    logic [OUT_W-1:0] mask, diff;

    for (genvar i = 0; i < OUT_W; i++) begin : g_mask
        assign mask[i] = (ora_q.act > ACT_W'(i));
    end

    always_comb begin
        diff  = (resp_a_i ^ resp_b_i ^ {OUT_W{ora_q.inv}}) & mask;
        ora_d = ora_q;
        if (start_i) begin
            ora_d.fail = 1'b0;
            ora_d.inv  = selfchk_i;
            ora_d.act  = act_i;
        end else if (scan_en_i) begin
            ora_d.fail = scan_in_i;
        end else if (cmp_en_i && (|diff)) begin
            ora_d.fail = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ora_q <= '0;
        else        ora_q <= ora_d;
    end

    assign fail_o = ora_q.fail;
endmodule

// File: rtl/bist_pair_tile.sv
`timescale 1ns/1ps
module bist_pair_tile #(
    parameter int unsigned IN_W   = 4,
    parameter int unsigned OUT_W  = 2,
    parameter int unsigned ADDR_W = 3,
    localparam int unsigned ACT_W = $clog2(OUT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              selfchk_i,
    input  logic [ACT_W-1:0]  act_outs_i,
    input  logic              scan_en_i,
    input  logic              scan_in_i,
    input  logic [OUT_W-1:0]  resp_a_i,
    input  logic [OUT_W-1:0]  resp_b_i,
    output logic [IN_W-1:0]   stim_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [OUT_W-1:0]  mem_wdata_o,
    output logic              mem_we_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              scan_out_o
);
    logic cmp_en;

    bist_seq #(.IN_W(IN_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .mode_i   (mode_i),
        .hold_i   (scan_en_i),
        .stim_o   (stim_o),
        .addr_o   (mem_addr_o),
        .wdata_o  (mem_wdata_o),
        .we_o     (mem_we_o),
        .cmp_en_o (cmp_en),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    bist_ora #(.OUT_W(OUT_W), .ACT_W(ACT_W)) u_ora (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .selfchk_i (selfchk_i),
        .act_i     (act_outs_i),
        .scan_en_i (scan_en_i),
        .scan_in_i (scan_in_i),
        .cmp_en_i  (cmp_en),
        .resp_a_i  (resp_a_i),
        .resp_b_i  (resp_b_i),
        .fail_o    (scan_out_o)
    );
endmodule

// File: rtl/bist_pair_tile_chk.sv
`timescale 1ns/1ps
module bist_pair_tile_chk #(
    parameter int unsigned IN_W   = 4,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              scan_en_i,
    input logic              scan_in_i,
    input logic [IN_W-1:0]   stim_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_we_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              scan_out_o
);
    AST_START_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o && !done_o && !scan_out_o);                                  // R2
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        scan_out_o && !start_i && !scan_en_i |=> scan_out_o);                           // R6
    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i && !scan_en_i && !scan_out_o |=> !scan_out_o);              // R5
    AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en_i && !start_i |=> scan_out_o == $past(scan_in_i));                      // R8
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && scan_en_i && !start_i |=> $stable(stim_o) && $stable(mem_addr_o) && $stable(mem_we_o)); // R8
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                                            // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o);                                                 // R7
    AST_WE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);                                                           // R4
endmodule

bind bist_pair_tile bist_pair_tile_chk #(.IN_W(IN_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_bist_pair_tile.sv
`timescale 1ns/1ps
module tb_bist_pair_tile;
    localparam int IN_W   = 4;
    localparam int OUT_W  = 2;
    localparam int ADDR_W = 3;
    localparam int NPAT   = 1 << IN_W;
    localparam int NA     = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, mode_i = 1'b0, selfchk_i = 1'b0;
    logic [1:0] act_outs_i = 2'd2;
    logic scan_en_i = 1'b0, scan_in_i = 1'b0;
    logic [OUT_W-1:0] resp_a_i, resp_b_i;
    logic [IN_W-1:0] stim_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [OUT_W-1:0] mem_wdata_o;
    logic mem_we_o, busy_o, done_o, scan_out_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // unit models and fault controls
    bit tb_mem = 1'b0;
    bit f_on = 1'b0;
    int f_pat = 0, f_bits = 0, f_addr = 0, f_bit = 0, f_val = 0;
    logic [OUT_W-1:0] mem_a [NA];
    logic [OUT_W-1:0] mem_b [NA];

    always #2 clk = ~clk;

    bist_pair_tile #(.IN_W(IN_W), .OUT_W(OUT_W), .ADDR_W(ADDR_W)) dut (.*);

    function automatic logic [OUT_W-1:0] ref_f(input logic [IN_W-1:0] x);
        return OUT_W'((x * 3) ^ (x >> 1));
    endfunction

    always_comb begin
        logic [OUT_W-1:0] rb;
        if (tb_mem) begin
            resp_a_i = mem_a[mem_addr_o];
            rb = mem_b[mem_addr_o];
            if (f_on && int'(mem_addr_o) == f_addr) rb[f_bit] = f_val[0];
            resp_b_i = rb;
        end else begin
            resp_a_i = ref_f(stim_o);
            resp_b_i = ref_f(stim_o) ^ ((f_on && int'(stim_o) == f_pat) ? OUT_W'(f_bits) : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NA; k++) begin
                mem_a[k] <= OUT_W'(k * 5 + 1);
                mem_b[k] <= OUT_W'(k * 3 + 2);
            end
        end else if (mem_we_o) begin
            mem_a[mem_addr_o] <= mem_wdata_o;
            mem_b[mem_addr_o] <= mem_wdata_o;
        end
    end

    task automatic chk(input bit ok, input string tag, input int actv, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, actv, expv);
        end
    endtask

    function automatic int lowmask(input int act);
        return (act >= OUT_W) ? ((1 << OUT_W) - 1) : ((1 << act) - 1);
    endfunction

    // called at a negedge; starts a counter-mode run and checks it to done
    task automatic run_comb(input bit sc, input int act, input bit fon, input int fpat, input int fbits);
        bit vis;
        int p;
        tb_mem = 1'b0; f_on = fon; f_pat = fpat; f_bits = fbits;
        mode_i = 1'b0; selfchk_i = sc; act_outs_i = 2'(act); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        vis = sc ? (act > 0) : (fon && ((fbits & lowmask(act)) != 0));
        p = sc ? 0 : fpat;
        for (int i = 0; i < NPAT; i++) begin
            chk(int'(stim_o) == i, "R3 counter vector", int'(stim_o), i);
            chk(busy_o && !done_o, "R2 busy during run", int'(busy_o), 1);
            chk(!mem_we_o && mem_addr_o == '0, "R3 memory side idle", int'(mem_we_o), 0);
            chk(scan_out_o == (vis && i > p), "R5 fail timing", int'(scan_out_o), int'(vis && i > p));
            @(negedge clk);
        end
        chk(done_o && !busy_o, "R7 done after last pattern", int'(done_o), 1);
        chk(scan_out_o == vis, "R7 final verdict", int'(scan_out_o), int'(vis));
    endtask

    task automatic run_march(input bit sc, input int act, input bit fon, input int faddr, input int fbit, input int fval);
        bit vis;
        tb_mem = 1'b1; f_on = fon; f_addr = faddr; f_bit = fbit; f_val = fval;
        mode_i = 1'b1; selfchk_i = sc; act_outs_i = 2'(act); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        vis = sc ? (act > 0) : (fon && fbit < act);
        for (int e = 0; e < 6; e++) begin
            for (int ai = 0; ai < NA; ai++) begin
                int a;
                int nops;
                a = (e == 3 || e == 4) ? (NA - 1 - ai) : ai;
                nops = (e == 0 || e == 5) ? 1 : 2;
                for (int o = 0; o < nops; o++) begin
                    bit w;
                    int wv;
                    w = (e == 0) || (o == 1);
                    wv = (e == 1 || e == 3) ? lowmask(OUT_W) : 0;
                    chk(int'(mem_addr_o) == a, "R4 march address", int'(mem_addr_o), a);
                    chk(mem_we_o == w, "R4 march op kind", int'(mem_we_o), int'(w));
                    if (w) chk(int'(mem_wdata_o) == wv, "R4 march write data", int'(mem_wdata_o), wv);
                    chk(stim_o == '0 && busy_o, "R4 counter idle in march", int'(stim_o), 0);
                    @(negedge clk);
                end
            end
        end
        chk(done_o && !busy_o, "R7 march done", int'(done_o), 1);
        chk(scan_out_o == vis, "R5 march verdict", int'(scan_out_o), int'(vis));
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !scan_out_o, "R1 reset flags", int'(busy_o | done_o | scan_out_o), 0);
        chk(stim_o == '0 && !mem_we_o && mem_addr_o == '0, "R1 reset outputs", int'(stim_o), 0);

        run_comb(0, 2, 0, 0, 0);                        // clean, pass
        for (int p = 0; p < NPAT; p++) run_comb(0, 2, 1, p, 1 + (p % 3));  // R5 fault at each vector
        run_comb(0, 1, 1, 6, 2);                        // R10 bit above width ignored
        run_comb(0, 0, 1, 6, 3);                        // R10 width 0 compares nothing
        run_comb(0, 3, 1, 9, 2);                        // R10 width above OUT_W compares all
        run_comb(1, 2, 0, 0, 0);                        // R9 self-check forces fail
        run_comb(1, 0, 0, 0, 0);                        // R9 with nothing compared

        // R6 sticky and R7 done held while idle
        run_comb(0, 2, 1, 4, 3);
        repeat (5) @(negedge clk);
        chk(scan_out_o == 1'b1, "R6 fail held while idle", int'(scan_out_o), 1);
        chk(done_o == 1'b1, "R7 done held while idle", int'(done_o), 1);

        // R8 scan shift while idle
        scan_en_i = 1'b1; scan_in_i = 1'b0;
        @(negedge clk);
        chk(scan_out_o == 1'b0, "R8 shift in 0", int'(scan_out_o), 0);
        scan_in_i = 1'b1;
        @(negedge clk);
        chk(scan_out_o == 1'b1, "R8 shift in 1", int'(scan_out_o), 1);
        scan_en_i = 1'b0; scan_in_i = 1'b0;
        @(negedge clk);
        chk(scan_out_o == 1'b1, "R6 shifted value held", int'(scan_out_o), 1);

        // march runs
        run_march(0, 2, 0, 0, 0, 0);
        for (int a = 0; a < NA; a++) run_march(0, 2, 1, a, a % 2, (a / 2) % 2);  // R5 stuck bit per address
        run_march(0, 1, 1, 3, 1, 1);                    // R10 masked bit in march
        run_march(1, 1, 0, 0, 0, 0);                    // R9 self-check in march

        // R8 hold mid-run: generator freezes on vector 3
        tb_mem = 1'b0; f_on = 1'b0;
        mode_i = 1'b0; selfchk_i = 1'b0; act_outs_i = 2'd2; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(int'(stim_o) == 3, "R3 vector before hold", int'(stim_o), 3);
        scan_en_i = 1'b1; scan_in_i = 1'b1;
        @(negedge clk);
        chk(int'(stim_o) == 3, "R8 vector held", int'(stim_o), 3);
        chk(scan_out_o == 1'b1, "R8 shift during run", int'(scan_out_o), 1);
        scan_in_i = 1'b0;
        @(negedge clk);
        chk(int'(stim_o) == 3, "R8 vector still held", int'(stim_o), 3);
        chk(scan_out_o == 1'b0, "R8 shift during run 0", int'(scan_out_o), 0);
        scan_en_i = 1'b0;
        @(negedge clk);
        chk(int'(stim_o) == 4, "R8 vector resumes", int'(stim_o), 4);
        repeat (NPAT - 5) @(negedge clk);
        chk(int'(stim_o) == NPAT - 1 && busy_o, "R8 last vector after hold", int'(stim_o), NPAT - 1);
        @(negedge clk);
        chk(done_o && !scan_out_o, "R7 done after held run", int'(scan_out_o), 0);

        // R2 restart mid-run into march mode
        f_on = 1'b1; f_pat = 2; f_bits = 1;
        mode_i = 1'b0; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (5) @(negedge clk);
        chk(scan_out_o == 1'b1, "R5 fail before restart", int'(scan_out_o), 1);
        run_march(0, 2, 0, 0, 0, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule